// File: doc/BRIEF.md
# HDLC Serial Receive Processor

This block receives a serial bit stream qualified by a data-enable input and delivers the packets it contains as a byte stream. The bits first pass through an optional self-synchronous descrambler with polynomial x^43+1. Bytes are then assembled in a selectable bit order. HDLC flags delimit the frames, and the zero bits inserted by the transmitter are removed. A frame check sequence, 16 or 32 bits wide, is verified at the closing flag. Each output byte comes with a valid strobe, and the packet is marked with start, end and error flags.

All configuration inputs are static: they are changed only while the block is held in reset. A clear-channel setting turns off framing and checking, so descrambled and ordered bytes flow straight to the output. An X.86 setting overrides the other frame-check controls. The output lags the input by a few cycles. When the check sequence is stripped, one extra packet byte plus the check bytes are held back, so that the end marker can be placed on the last payload byte.

Top module: `hdlc_rx_proc`

## Requirements
- R1: A bit is accepted on a rising clock edge only when `rx_en` is at its active level: high when `cfg_en_active_low` is 0, low when it is 1. Cycles with the enable inactive leave the output stream unchanged.
- R2: With `cfg_descr_off` = 0, each accepted bit is XORed with the accepted input bit 43 positions earlier. The history starts as zeros at reset. With `cfg_descr_off` = 1, bits pass unchanged.
- R3: With `cfg_lsb_first` = 0, the first bit of each byte becomes bit 7 of the output byte. With `cfg_lsb_first` = 1, it becomes bit 0.
- R4: The pattern 0 followed by six 1s and a 0 (0x7E) is a flag. A flag opens a frame and also closes the open one. Inside a frame, a 0 that follows exactly five 1s is dropped. A frame with no complete byte produces no output.
- R5: Seven 1s in a row inside a frame abort it. If any byte of the frame was delivered, the last delivered byte carries end and error. Reception then resumes at the next flag.
- R6: With frame checking on and 32-bit mode, the CRC-32 (reflected 0xEDB88320, preset all ones, check bytes sent low byte first) runs over the whole frame. The end marker has error = 0 exactly when the remainder is 0xDEBB20E3.
- R7: With `cfg_fcs16` = 1 and checking on, CRC-CCITT (reflected 0x8408, preset all ones, residue 0xF0B8) is used with 2 check bytes. `cfg_fcs16` has no effect when checking is off.
- R8: With checking on, the check bytes are removed from the output unless `cfg_fcs_keep` = 1. `cfg_fcs_keep` has no effect when checking is off.
- R9: With `cfg_fcs_off` = 1 and `cfg_x86` = 0, no check is made. Every frame byte is delivered, and error is raised only by framing faults.
- R10: `cfg_x86` = 1 forces checking on, 32-bit mode and stripping, whatever `cfg_fcs_off`, `cfg_fcs16` and `cfg_fcs_keep` say.
- R11: With checking on, a frame shorter than its check length plus one byte ends with error. When such a frame is stripped, its first byte is delivered alone with start, end and error. A frame whose bit count at the closing flag is not a whole number of bytes ends with error in every framed mode.
- R12: With `cfg_clear_chan` = 1, every 8 accepted bits after reset form one output byte, ordered per R3 and descrambled per R2. There are no start or end markers and no flag, stuffing or check handling.
- R13: After reset `out_valid` is 0. Each valid strobe carries one byte. Start marks the first byte of a packet and end marks its last. Error is only ever set together with end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit | input | 1 | Serial receive data |
| rx_en | input | 1 | Bit qualifier, active level set by cfg_en_active_low |
| cfg_en_active_low | input | 1 | 1: low rx_en accepts the bit |
| cfg_descr_off | input | 1 | 1: bypass the x^43+1 descrambler |
| cfg_lsb_first | input | 1 | 1: first received bit is byte bit 0 |
| cfg_clear_chan | input | 1 | 1: raw byte stream, no framing or checking |
| cfg_fcs_off | input | 1 | 1: no frame check (unless cfg_x86) |
| cfg_fcs16 | input | 1 | 1: 16-bit check instead of 32-bit |
| cfg_fcs_keep | input | 1 | 1: pass check bytes to the output |
| cfg_x86 | input | 1 | 1: force checking on, 32-bit, stripped |
| out_valid | output | 1 | Output byte strobe |
| out_data | output | 8 | Output byte |
| out_sop | output | 1 | First byte of a packet |
| out_eop | output | 1 | Last byte of a packet |
| out_err | output | 1 | Packet error, valid with out_eop |

## Verification
The assertions take for granted that the configuration inputs hold still between resets. They also take for granted that the stream starts in step with the descrambler history, which is zero at reset, so that framing state follows only from accepted bits. The stimulus changes configuration only inside a reset pulse. It builds every frame with a bench-side scrambler whose history also starts at zero, and it applies stuffing to all frame content so that flags and aborts occur only where they are placed on purpose. Gap cycles drive random data with the enable held inactive. Those cycles must leave the byte stream unchanged.

// File: rtl/hrx_pkg.sv
package hrx_pkg;
  localparam int SCR_TAPS     = 43;
  localparam int FCS16_BYTES  = 2;
  localparam int FCS32_BYTES  = 4;
  localparam logic [15:0] CRC16_POLY = 16'h8408;
  localparam logic [15:0] CRC16_RES  = 16'hF0B8;
  localparam logic [31:0] CRC32_POLY = 32'hEDB88320;
  localparam logic [31:0] CRC32_RES  = 32'hDEBB20E3;

  // one byte into a reflected CRC-CCITT register, bit 0 first
  function automatic logic [15:0] crc16_next(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC16_POLY;
      else             r = r >> 1;
    end
    return r;
  endfunction

  // one byte into a reflected CRC-32 register, bit 0 first
  function automatic logic [31:0] crc32_next(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC32_POLY;
      else             r = r >> 1;
    end
    return r;
  endfunction

  // arrival-ordered bits (first arrival at bit 7) to the configured byte order
  function automatic logic [7:0] order_byte(input logic [7:0] arrived, input logic lsb_first);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = lsb_first ? arrived[7-i] : arrived[i];
    return r;
  endfunction
endpackage

// File: rtl/hrx_descrambler.sv
module hrx_descrambler #(
  parameter int TAPS = hrx_pkg::SCR_TAPS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_vld,
  input  logic in_bit,
  input  logic bypass,
  output logic out_vld,
  output logic out_bit
);
  logic [TAPS-1:0] hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist    <= '0;
      out_vld <= 1'b0;
      out_bit <= 1'b0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        hist    <= {hist[TAPS-2:0], in_bit};
        out_bit <= in_bit ^ (hist[TAPS-1] & ~bypass);
      end
    end
  end
endmodule

// File: rtl/hrx_deframer.sv
module hrx_deframer #(
  parameter int FLAG_ONES  = 6,
  parameter int STUFF_ONES = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_vld,
  input  logic       bit_in,
  input  logic       lsb_first,
  input  logic       clear_chan,
  output logic       byte_vld,
  output logic [7:0] byte_data,
  output logic       byte_first,
  output logic       end_vld,
  output logic       end_bad
);
  import hrx_pkg::*;

  localparam int HOLD_BITS = FLAG_ONES + 1;
  localparam int WIN       = 8 + HOLD_BITS;
  localparam int CNT_W     = $clog2(WIN + 1);
  localparam int ONES_MAX  = FLAG_ONES + 1;
  localparam int ONES_W    = $clog2(ONES_MAX + 1);

  logic              in_frame, started;
  logic [ONES_W-1:0] ones, ones_nx;
  logic [WIN-2:0]    win;
  logic [WIN-1:0]    win_nx;
  logic [CNT_W-1:0]  cnt;
  logic [6:0]        cc_sr;
  logic [7:0]        cc_nx;
  logic [2:0]        cc_cnt;
  logic              framed, flag_hit, abort_hit, stuff_hit, take, win_full;

  always_comb begin
    framed    = bit_vld && !clear_chan;
    flag_hit  = framed && !bit_in && (ones == ONES_W'(FLAG_ONES));
    abort_hit = framed && bit_in && in_frame && (ones == ONES_W'(FLAG_ONES));
    stuff_hit = framed && !bit_in && in_frame && (ones == ONES_W'(STUFF_ONES));
    take      = framed && in_frame && !flag_hit && !abort_hit && !stuff_hit;
    win_nx    = {win, bit_in};
    win_full  = take && (cnt == CNT_W'(WIN - 1));
    if (!bit_in)                          ones_nx = '0;
    else if (ones == ONES_W'(ONES_MAX))   ones_nx = ones;
    else                                  ones_nx = ones + 1'b1;
    cc_nx     = {cc_sr, bit_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame   <= 1'b0;
      started    <= 1'b0;
      ones       <= '0;
      win        <= '0;
      cnt        <= '0;
      cc_sr      <= '0;
      cc_cnt     <= '0;
      byte_vld   <= 1'b0;
      byte_data  <= '0;
      byte_first <= 1'b0;
      end_vld    <= 1'b0;
      end_bad    <= 1'b0;
    end else begin
      byte_vld <= 1'b0;
      end_vld  <= 1'b0;
      if (clear_chan) begin
        if (bit_vld) begin
          cc_sr  <= cc_nx[6:0];
          cc_cnt <= cc_cnt + 1'b1;
          if (cc_cnt == 3'd7) begin
            byte_vld   <= 1'b1;
            byte_data  <= order_byte(cc_nx, lsb_first);
            byte_first <= 1'b0;
          end
        end
      end else if (bit_vld) begin
        ones <= ones_nx;
        if (take) begin
          win <= win_nx[WIN-2:0];
          if (win_full) begin
            byte_vld   <= 1'b1;
            byte_data  <= order_byte(win_nx[WIN-1 -: 8], lsb_first);
            byte_first <= !started;
            started    <= 1'b1;
            cnt        <= CNT_W'(HOLD_BITS);
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        if (flag_hit) begin
          if (in_frame && started) begin
            end_vld <= 1'b1;
            end_bad <= (cnt != CNT_W'(HOLD_BITS));
          end
          in_frame <= 1'b1;
          started  <= 1'b0;
          cnt      <= '0;
        end
        if (abort_hit) begin
          if (started) begin
            end_vld <= 1'b1;
            end_bad <= 1'b1;
          end
          in_frame <= 1'b0;
          started  <= 1'b0;
          cnt      <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/hrx_fcs_stage.sv
module hrx_fcs_stage #(
  parameter int NB_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_vld,
  input  logic [7:0] byte_data,
  input  logic       byte_first,
  input  logic       end_vld,
  input  logic       end_bad,
  input  logic       clear_chan,
  input  logic       fcs_on,
  input  logic       fcs16,
  input  logic       strip,
  output logic       o_vld,
  output logic [7:0] o_data,
  output logic       o_sop,
  output logic       o_eop,
  output logic       o_err
);
  import hrx_pkg::*;

  localparam int MAX_HOLD = FCS32_BYTES + 1;
  localparam int HC_W     = $clog2(MAX_HOLD + 1);
  localparam logic [NB_W-1:0] NB_MAX = '1;

  logic [MAX_HOLD-1:0][7:0] hold;
  logic [HC_W-1:0]          hcnt, hold_len;
  logic [NB_W-1:0]          nb, nb_nx, nb_min;
  logic [15:0]              crc16, crc16_nx;
  logic [31:0]              crc32, crc32_nx;
  logic                     sent, hold_full, crc_ok, too_short, end_err;

  always_comb begin
    hold_len  = strip ? (fcs16 ? HC_W'(FCS16_BYTES + 1) : HC_W'(FCS32_BYTES + 1)) : HC_W'(1);
    nb_min    = fcs16 ? NB_W'(FCS16_BYTES + 1) : NB_W'(FCS32_BYTES + 1);
    hold_full = (hcnt == hold_len);
    crc16_nx  = crc16_next(byte_first ? 16'hFFFF : crc16, byte_data);
    crc32_nx  = crc32_next(byte_first ? 32'hFFFF_FFFF : crc32, byte_data);
    if (byte_first)          nb_nx = NB_W'(1);
    else if (nb == NB_MAX)   nb_nx = nb;
    else                     nb_nx = nb + 1'b1;
    crc_ok    = fcs16 ? (crc16 == CRC16_RES) : (crc32 == CRC32_RES);
    too_short = (nb < nb_min);
    end_err   = end_bad | (fcs_on & (too_short | !crc_ok));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold   <= '0;
      hcnt   <= '0;
      nb     <= '0;
      crc16  <= '1;
      crc32  <= '1;
      sent   <= 1'b0;
      o_vld  <= 1'b0;
      o_data <= '0;
      o_sop  <= 1'b0;
      o_eop  <= 1'b0;
      o_err  <= 1'b0;
    end else begin
      o_vld <= 1'b0;
      o_sop <= 1'b0;
      o_eop <= 1'b0;
      o_err <= 1'b0;
      if (clear_chan) begin
        if (byte_vld) begin
          o_vld  <= 1'b1;
          o_data <= byte_data;
        end
      end else if (byte_vld) begin
        crc16 <= crc16_nx;
        crc32 <= crc32_nx;
        nb    <= nb_nx;
        hold  <= {hold[MAX_HOLD-2:0], byte_data};
        if (hold_full) begin
          o_vld  <= 1'b1;
          o_data <= hold[hold_len - 1'b1];
          o_sop  <= !sent;
          sent   <= 1'b1;
        end else begin
          hcnt <= hcnt + 1'b1;
        end
      end else if (end_vld && hcnt != '0) begin
        o_vld  <= 1'b1;
        o_data <= hold[hcnt - 1'b1];
        o_sop  <= !sent;
        o_eop  <= 1'b1;
        o_err  <= end_err;
        hcnt   <= '0;
        sent   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hdlc_rx_proc.sv
module hdlc_rx_proc #(
  parameter int SCR_TAPS  = hrx_pkg::SCR_TAPS,
  parameter int FLAG_ONES = 6,
  parameter int NB_W      = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_bit,
  input  logic       rx_en,
  input  logic       cfg_en_active_low,
  input  logic       cfg_descr_off,
  input  logic       cfg_lsb_first,
  input  logic       cfg_clear_chan,
  input  logic       cfg_fcs_off,
  input  logic       cfg_fcs16,
  input  logic       cfg_fcs_keep,
  input  logic       cfg_x86,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_sop,
  output logic       out_eop,
  output logic       out_err
);
  // named internal events, observed by the bound checker
  logic       bit_acc;
  logic       d_vld, d_bit;
  logic       fr_byte_vld, fr_first, fr_end, fr_bad;
  logic [7:0] fr_byte;
  logic       eff_fcs_on, eff_fcs16, eff_strip;

  assign bit_acc    = rx_en ^ cfg_en_active_low;
  assign eff_fcs_on = cfg_x86 | ~cfg_fcs_off;
  assign eff_fcs16  = ~cfg_x86 & cfg_fcs16;
  assign eff_strip  = eff_fcs_on & (cfg_x86 | ~cfg_fcs_keep);

  hrx_descrambler #(.TAPS(SCR_TAPS)) u_descr (
    .clk(clk), .rst_n(rst_n), .in_vld(bit_acc), .in_bit(rx_bit),
    .bypass(cfg_descr_off), .out_vld(d_vld), .out_bit(d_bit)
  );

  hrx_deframer #(.FLAG_ONES(FLAG_ONES), .STUFF_ONES(FLAG_ONES - 1)) u_defr (
    .clk(clk), .rst_n(rst_n), .bit_vld(d_vld), .bit_in(d_bit),
    .lsb_first(cfg_lsb_first), .clear_chan(cfg_clear_chan),
    .byte_vld(fr_byte_vld), .byte_data(fr_byte), .byte_first(fr_first),
    .end_vld(fr_end), .end_bad(fr_bad)
  );

  hrx_fcs_stage #(.NB_W(NB_W)) u_fcs (
    .clk(clk), .rst_n(rst_n), .byte_vld(fr_byte_vld), .byte_data(fr_byte),
    .byte_first(fr_first), .end_vld(fr_end), .end_bad(fr_bad),
    .clear_chan(cfg_clear_chan), .fcs_on(eff_fcs_on), .fcs16(eff_fcs16),
    .strip(eff_strip), .o_vld(out_valid), .o_data(out_data), .o_sop(out_sop),
    .o_eop(out_eop), .o_err(out_err)
  );
endmodule

// File: rtl/hrx_rx_chk.sv
module hrx_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_en,
  input logic cfg_en_active_low,
  input logic cfg_clear_chan,
  input logic out_valid,
  input logic out_sop,
  input logic out_eop,
  input logic out_err,
  input logic d_vld,
  input logic fr_byte_vld,
  input logic fr_end
);
  logic in_pkt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_pkt <= 1'b0;
    else if (out_valid && out_eop) in_pkt <= 1'b0;
    else if (out_valid && out_sop) in_pkt <= 1'b1;
  end

  // R1
  en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en == cfg_en_active_low) |=> !d_vld);

  // R4
  byte_end_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fr_byte_vld && fr_end));

  // R12
  cc_no_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_clear_chan && out_valid) |-> (!out_sop && !out_eop));

  // R13
  marks_need_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sop || out_eop) |-> out_valid);

  // R13
  err_with_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> out_eop);

  // R13
  sop_nesting_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sop) |-> !in_pkt);

  // R13
  out_follows_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(fr_byte_vld || fr_end));
endmodule

bind hdlc_rx_proc hrx_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .cfg_en_active_low(cfg_en_active_low),
  .cfg_clear_chan(cfg_clear_chan), .out_valid(out_valid), .out_sop(out_sop),
  .out_eop(out_eop), .out_err(out_err), .d_vld(d_vld),
  .fr_byte_vld(fr_byte_vld), .fr_end(fr_end)
);

// File: tb/hdlc_rx_proc_tb.sv
module hdlc_rx_proc_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, rx_bit = 1'b0, rx_en = 1'b0;
  logic cfg_en_active_low = 0, cfg_descr_off = 0, cfg_lsb_first = 0, cfg_clear_chan = 0;
  logic cfg_fcs_off = 0, cfg_fcs16 = 0, cfg_fcs_keep = 0, cfg_x86 = 0;
  logic out_valid, out_sop, out_eop, out_err;
  logic [7:0] out_data;

  hdlc_rx_proc u_dut (.*);

  int checks = 0, errors = 0;
  logic [7:0] got_d [0:511];
  logic [2:0] got_f [0:511];
  logic [7:0] exp_d [0:511];
  logic [2:0] exp_f [0:511];
  int n_got = 0, n_exp = 0;
  logic [42:0] tx_hist;
  int ones_tx = 0, gap_ctr = 0, seed = 3;
  bit gap_mode = 0;
  logic [7:0] frm [0:63];

  always @(negedge clk)
    if (rst_n && out_valid && n_got < 512) begin
      got_d[n_got] = out_data;
      got_f[n_got] = {out_sop, out_eop, out_err};
      n_got++;
    end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic restart();
    @(negedge clk);
    rst_n = 1'b0;
    rx_en = cfg_en_active_low;
    tx_hist = '0;
    n_got = 0;
    n_exp = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send_raw(input bit b);
    logic s;
    s = cfg_descr_off ? b : (b ^ tx_hist[42]);
    tx_hist = {tx_hist[41:0], s};
    @(negedge clk);
    rx_bit = s;
    rx_en  = !cfg_en_active_low;
    if (gap_mode) begin
      gap_ctr++;
      if (gap_ctr % 3 == 0) begin
        @(negedge clk);
        rx_en  = cfg_en_active_low;
        rx_bit = 1'($urandom & 1);
      end
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      rx_en = cfg_en_active_low;
    end
  endtask

  task automatic send_flag();
    send_raw(0);
    repeat (6) send_raw(1);
    send_raw(0);
  endtask

  task automatic send_stuffed(input bit b);
    send_raw(b);
    if (b) begin
      ones_tx++;
      if (ones_tx == 5) begin
        send_raw(0);
        ones_tx = 0;
      end
    end else ones_tx = 0;
  endtask

  task automatic send_byte(input logic [7:0] d, input bit stuff);
    for (int i = 0; i < 8; i++) begin
      bit b;
      b = cfg_lsb_first ? d[i] : d[7-i];
      if (stuff) send_stuffed(b);
      else send_raw(b);
    end
  endtask

  function automatic logic [31:0] crc_calc(input int n, input int width);
    logic [31:0] c;
    logic [31:0] pl;
    c  = (width == 16) ? 32'h0000FFFF : 32'hFFFFFFFF;
    pl = (width == 16) ? 32'h00008408 : 32'hEDB88320;
    for (int k = 0; k < n; k++)
      for (int i = 0; i < 8; i++)
        c = (c >> 1) ^ ({32{c[0] ^ frm[k][i]}} & pl);
    return c;
  endfunction

  task automatic push_exp(input logic [7:0] d, input logic [2:0] f);
    exp_d[n_exp] = d;
    exp_f[n_exp] = f;
    n_exp++;
  endtask

  // builds, sends and models one frame; tx_fcs = check bytes appended on the line
  task automatic send_frame(input int n_pay, input int tx_fcs, input bit corrupt, input int extra);
    int t, le, nout;
    bit fe, se, errx;
    logic [31:0] c;
    for (int i = 0; i < n_pay; i++)
      frm[i] = (i % 4 == 1) ? 8'h7E : (i % 4 == 3) ? 8'hFF : 8'((i * 29 + seed) & 255);
    seed = seed + 11;
    t = n_pay;
    if (tx_fcs > 0) begin
      c = ~crc_calc(n_pay, tx_fcs * 8);
      for (int j = 0; j < tx_fcs; j++) frm[t + j] = c[8*j +: 8];
      t = t + tx_fcs;
    end
    if (corrupt) frm[0] = frm[0] ^ 8'h01;
    send_flag();
    ones_tx = 0;
    for (int k = 0; k < t; k++) send_byte(frm[k], 1);
    for (int k = 0; k < extra; k++) send_stuffed(0);
    send_flag();
    fe = cfg_x86 || !cfg_fcs_off;
    le = (!cfg_x86 && cfg_fcs16) ? 2 : 4;
    se = fe && (cfg_x86 || !cfg_fcs_keep);
    errx = (extra % 8 != 0) || (fe && (corrupt || t < le + 1));
    nout = se ? ((t >= le + 1) ? t - le : 1) : t;
    for (int k = 0; k < nout; k++)
      push_exp(frm[k], {k == 0, k == nout - 1, (k == nout - 1) && errx});
  endtask

  task automatic compare(input string req);
    idle(30);
    check(n_got == n_exp, req, n_got, n_exp);
    for (int k = 0; k < n_exp && k < n_got; k++)
      check({got_d[k], got_f[k]} == {exp_d[k], exp_f[k]}, req,
            {got_d[k], got_f[k]}, {exp_d[k], exp_f[k]});
  endtask

  task automatic std_frames(input int tx_fcs);
    send_flag();
    send_frame(1, tx_fcs, 0, 0);
    send_frame(2, tx_fcs, 0, 0);
    send_frame(5, tx_fcs, 0, 0);
    send_frame(9, tx_fcs, 0, 0);
  endtask

  task automatic set_cfg(input bit al, input bit dof, input bit lsb, input bit cc,
                         input bit fof, input bit f16, input bit keep, input bit x86);
    cfg_en_active_low = al; cfg_descr_off = dof; cfg_lsb_first = lsb; cfg_clear_chan = cc;
    cfg_fcs_off = fof; cfg_fcs16 = f16; cfg_fcs_keep = keep; cfg_x86 = x86;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R13 watchdog actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R13: reset state
    set_cfg(0, 0, 0, 0, 0, 0, 0, 0);
    restart();
    idle(3);
    check(out_valid == 1'b0, "R13 reset", out_valid, 0);

    // R6 R2 R4 R3: default settings, 32-bit check stripped
    std_frames(4);
    compare("R6/R4");

    // R3 R1: lsb first with inactive-enable gaps carrying random data
    set_cfg(0, 0, 1, 0, 0, 0, 0, 0); restart(); gap_mode = 1;
    std_frames(4);
    compare("R3/R1");

    // R1: active-low enable
    set_cfg(1, 0, 0, 0, 0, 0, 0, 0); restart();
    std_frames(4);
    compare("R1");
    gap_mode = 0;

    // R2: descrambler bypassed
    set_cfg(0, 1, 0, 0, 0, 0, 0, 0); restart();
    std_frames(4);
    compare("R2");

    // R7: 16-bit check
    set_cfg(0, 0, 0, 0, 0, 1, 0, 0); restart();
    std_frames(2);
    compare("R7");

    // R8: check bytes kept
    set_cfg(0, 0, 1, 0, 0, 0, 1, 0); restart();
    std_frames(4);
    compare("R8");

    // R9 R7 R8: checking off, fcs16 and keep have no effect
    set_cfg(0, 0, 0, 0, 1, 1, 0, 0); restart();
    std_frames(0);
    compare("R9/R7/R8");

    // R10: x86 overrides every other check control
    set_cfg(0, 0, 0, 0, 1, 1, 1, 1); restart();
    std_frames(4);
    send_frame(4, 4, 1, 0);
    compare("R10");

    // R6: corrupted frames flagged, good ones not
    set_cfg(0, 0, 0, 0, 0, 0, 0, 0); restart();
    send_flag();
    send_frame(3, 4, 1, 0);
    send_frame(6, 4, 0, 0);
    send_frame(7, 4, 1, 0);
    compare("R6 bad crc");

    // R11: short and misaligned frames
    set_cfg(0, 0, 0, 0, 0, 0, 0, 0); restart();
    send_flag();
    send_frame(0, 4, 0, 0);
    send_frame(4, 4, 0, 3);
    send_frame(3, 4, 0, 0);
    compare("R11 32");
    set_cfg(0, 0, 0, 0, 0, 1, 0, 0); restart();
    send_flag();
    send_frame(0, 2, 0, 0);
    send_frame(1, 2, 0, 0);
    compare("R11 16");

    // R5: abort after three zero bytes, checking off
    set_cfg(0, 0, 0, 0, 1, 0, 0, 0); restart();
    send_flag();
    send_flag();
    for (int k = 0; k < 3; k++) send_byte(8'h00, 1);
    repeat (12) send_raw(1);
    push_exp(8'h00, 3'b100);
    push_exp(8'h00, 3'b011);
    send_frame(3, 0, 0, 0);
    compare("R5");

    // R12: clear channel, lsb first, descrambled
    set_cfg(0, 0, 1, 1, 0, 0, 0, 0); restart();
    for (int k = 0; k < 20; k++) begin
      logic [7:0] v;
      v = (k % 5 == 0) ? 8'h7E : (k % 5 == 1) ? 8'hFF : 8'((k * 53 + 7) & 255);
      send_byte(v, 0);
      push_exp(v, 3'b000);
    end
    compare("R12");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule